// File: doc/BRIEF.md
# Protection-filter blocked-access handler

This block sits beside a security filter that guards a memory region divided into equal, power-of-two sized blocks. Each block owns one bit in a lookup table that marks it as a secure or a non-secure block. When the filter refuses a transfer, it hands the transfer to this block. The block answers it one cycle later with zero read data and with either an OKAY or an ERROR response, as software selects. A refused read returns zero and a refused write changes nothing.

The first refused transfer after the interrupt status was last cleared latches diagnostic words: the full address, the requester ID, a non-secure flag and the table bit of the addressed block. The same transfer also raises the status bit. Later refused transfers are still answered, but they leave the latched words alone until software clears the status. The interrupt line is the status gated by an enable bit. A simple register port gives access to the control bit, the status bit, the enable bit, the clear and set strobes, the two diagnostic words and the lookup table.

Top module: `prot_block_handler`

## Requirements
- R1: After reset, `irq` and `rsp_valid` are 0, and every register and every lookup-table word reads 0.
- R2: A refused transfer presented in cycle N gives `rsp_valid`=1 in cycle N+1 with `rsp_rdata`=0. No response appears without a transfer. Reads and writes are handled the same way.
- R3: `rsp_err` in cycle N+1 equals control bit 0 (offset 0x000) as it was in cycle N. A value of 1 gives an ERROR response and 0 gives OKAY.
- R4: A refused transfer that arrives while status is 0 stores its address, zero-extended, in diag word A (offset 0x02C) and sets status (offset 0x020, bit 0). Both are visible in the next cycle.
- R5: On that capture, diag word B (offset 0x030) becomes: bits 15:0 = requester ID, bit 16 = inverse of `blk_secure`, bit 17 = lookup-table bit of the addressed block, bits 31:18 = 0.
- R6: Table lookup: block = address / 2^BLK_SHIFT. The bit lives in table word block/32 (register offset 0x400 + 4*word), at bit position block mod 32. A capture in the same cycle as a write to that table word uses the old word.
- R7: While status is 1, refused transfers are still answered, but both diag words keep their values.
- R8: `irq` equals status AND enable (offset 0x028, bit 0), and follows a change of either one cycle after it.
- R9: Writing 1 in bit 0 at offset 0x024 clears status and re-arms capture. Writing 0 there has no effect.
- R10: Writing 1 in bit 0 at offset 0x034 sets status without changing either diag word. Writing 0 there has no effect.
- R11: Writes to offsets 0x020, 0x02C and 0x030 are ignored. Offsets 0x024 and 0x034, unmapped offsets, and table words past the last one all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | A refused transfer is presented this cycle |
| blk_addr | input | ADDR_W | Byte address of the refused transfer |
| blk_secure | input | 1 | Security attribute of the transfer (1 = secure) |
| blk_req_id | input | 16 | Requester ID of the transfer |
| rsp_valid | output | 1 | Response for the transfer of the previous cycle |
| rsp_err | output | 1 | 1 = ERROR response, 0 = OKAY |
| rsp_rdata | output | DATA_W | Read data returned, always zero |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the current state |
| irq | output | 1 | Interrupt request |

## Verification
The response to a transfer, every register update and the resulting change on `irq` all appear one clock after the stimulus. A register read returns its data in the same cycle as the read. The bench therefore drives inputs just after each falling edge and compares the response and `irq` at the next falling edge, against a model that steps on the rising edge between them. A read is compared a moment after it is driven, against the model state left by the last rising edge. Same-cycle collisions are driven on purpose, and a long mixed random phase stresses them further: a capture alongside a table write, and a clear alongside a further refused transfer.

// File: rtl/pbh_pkg.sv
`timescale 1ns/1ps
package pbh_pkg;

    localparam int REG_AW = 12;

    // register offsets (bit 0 carries the control, enable, clear and set values)
    localparam logic [REG_AW-1:0] OFF_CTRL  = 12'h000;
    localparam logic [REG_AW-1:0] OFF_STAT  = 12'h020;
    localparam logic [REG_AW-1:0] OFF_ICLR  = 12'h024;
    localparam logic [REG_AW-1:0] OFF_IEN   = 12'h028;
    localparam logic [REG_AW-1:0] OFF_DIAGA = 12'h02C;
    localparam logic [REG_AW-1:0] OFF_DIAGB = 12'h030;
    localparam logic [REG_AW-1:0] OFF_ISET  = 12'h034;
    // lookup-table window: offset bits 11:10 == 2'b01, word index in bits 9:2
    localparam logic [1:0]        LUT_WIN   = 2'b01;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_clr;
        logic wr_ien;
        logic wr_set;
        logic bit0;
    } reg_cmd_t;

    typedef struct packed {
        logic        err_cfg;
        logic        stat;
        logic        ien;
        logic [31:0] diag_a;
        logic [31:0] diag_b;
        logic        rsp_v;
        logic        rsp_err;
    } cap_st_t;

    function automatic int lut_words(input int aw, input int bs);
        return ((1 << (aw - bs)) + 31) / 32;
    endfunction

    function automatic logic [31:0] pack_diag_b(input logic [15:0] rid,
                                                 input logic        secure,
                                                 input logic        ns_bit);
        logic [31:0] w;
        w        = '0;
        w[15:0]  = rid;
        w[16]    = ~secure;
        w[17]    = ns_bit;
        return w;
    endfunction

endpackage

// File: rtl/pbh_lut.sv
`timescale 1ns/1ps
module pbh_lut #(
    parameter int ADDR_W    = 16,
    parameter int BLK_SHIFT = 8,
    localparam int BN_W     = ADDR_W - BLK_SHIFT,
    localparam int NWORDS   = pbh_pkg::lut_words(ADDR_W, BLK_SHIFT),
    localparam int IDX_W    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_word,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_bit
);

    logic [31:0] word_d [NWORDS];
    logic [31:0] word_q [NWORDS];

    generate
        for (genvar w = 0; w < NWORDS; w++) begin : g_word
            always_comb begin
                word_d[w] = word_q[w];
                if (wr_en && (wr_idx == IDX_W'(w))) begin
                    word_d[w] = wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q[w] <= '0;
                end else begin
                    word_q[w] <= word_d[w];
                end
            end
        end
    endgenerate

    // block number, then word = block / 32 and bit = block mod 32
    logic [BN_W-1:0]  blk_num;
    logic [IDX_W-1:0] lk_word;
    logic [4:0]       lk_pos;

    always_comb begin
        blk_num  = look_addr[ADDR_W-1:BLK_SHIFT];
        lk_word  = IDX_W'(blk_num >> 5);
        lk_pos   = blk_num[4:0];
        look_bit = word_q[lk_word][lk_pos];
        rd_word  = word_q[rd_idx];
    end

endmodule

// File: rtl/pbh_regdec.sv
`timescale 1ns/1ps
module pbh_regdec
    import pbh_pkg::*;
#(
    parameter int NWORDS = 8,
    parameter int IDX_W  = 3
) (
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              wbit0,
    input  logic              err_cfg,
    input  logic              stat,
    input  logic              ien,
    input  logic [31:0]       diag_a,
    input  logic [31:0]       diag_b,
    input  logic [31:0]       lut_rword,
    output reg_cmd_t          cmd,
    output logic              lut_we,
    output logic [IDX_W-1:0]  lut_idx,
    output logic [31:0]       reg_rdata
);

    logic wr;
    logic rd;
    logic in_lut;

    always_comb begin
        wr      = reg_en && reg_we;
        rd      = reg_en && !reg_we;
        in_lut  = (reg_addr[11:10] == LUT_WIN)
               && (reg_addr[1:0] == 2'b00)
               && (int'(reg_addr[9:2]) < NWORDS);
        lut_idx = IDX_W'(reg_addr[9:2]);
        lut_we  = wr && in_lut;

        cmd.wr_ctrl = wr && (reg_addr == OFF_CTRL);
        cmd.wr_clr  = wr && (reg_addr == OFF_ICLR);
        cmd.wr_ien  = wr && (reg_addr == OFF_IEN);
        cmd.wr_set  = wr && (reg_addr == OFF_ISET);
        cmd.bit0    = wbit0;

        reg_rdata = '0;
        if (rd) begin
            if (in_lut) begin
                reg_rdata = lut_rword;
            end else begin
                case (reg_addr)
                    OFF_CTRL:  reg_rdata = {31'd0, err_cfg};
                    OFF_STAT:  reg_rdata = {31'd0, stat};
                    OFF_IEN:   reg_rdata = {31'd0, ien};
                    OFF_DIAGA: reg_rdata = diag_a;
                    OFF_DIAGB: reg_rdata = diag_b;
                    default:   reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pbh_capture.sv
`timescale 1ns/1ps
module pbh_capture
    import pbh_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    input  logic [ADDR_W-1:0] blk_addr,
    input  logic              blk_secure,
    input  logic [15:0]       blk_req_id,
    input  logic              lut_bit,
    input  reg_cmd_t          cmd,
    output logic              err_cfg,
    output logic              stat,
    output logic              ien,
    output logic [31:0]       diag_a,
    output logic [31:0]       diag_b,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic              irq
);

    cap_st_t st_d;
    cap_st_t st_q;
    logic    take;

    always_comb begin
        st_d = st_q;
        take = blk_valid && !st_q.stat;

        st_d.rsp_v   = blk_valid;
        st_d.rsp_err = blk_valid && st_q.err_cfg;

        if (cmd.wr_ctrl) st_d.err_cfg = cmd.bit0;
        if (cmd.wr_ien)  st_d.ien     = cmd.bit0;

        if (cmd.wr_clr && cmd.bit0) st_d.stat = 1'b0;
        if (cmd.wr_set && cmd.bit0) st_d.stat = 1'b1;

        if (take) begin
            st_d.stat   = 1'b1;
            st_d.diag_a = 32'(blk_addr);
            st_d.diag_b = pack_diag_b(blk_req_id, blk_secure, lut_bit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        err_cfg   = st_q.err_cfg;
        stat      = st_q.stat;
        ien       = st_q.ien;
        diag_a    = st_q.diag_a;
        diag_b    = st_q.diag_b;
        rsp_valid = st_q.rsp_v;
        rsp_err   = st_q.rsp_err;
        irq       = st_q.stat && st_q.ien;
    end

endmodule

// File: rtl/prot_block_handler.sv
`timescale 1ns/1ps
module prot_block_handler
    import pbh_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_SHIFT = 8,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    input  logic [ADDR_W-1:0] blk_addr,
    input  logic              blk_secure,
    input  logic [15:0]       blk_req_id,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    localparam int NWORDS = lut_words(ADDR_W, BLK_SHIFT);
    localparam int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    reg_cmd_t         cmd;
    logic             lut_we;
    logic [IDX_W-1:0] lut_idx;
    logic [31:0]      lut_rword;
    logic             lut_bit;
    logic             err_cfg;
    logic             stat;
    logic             ien;
    logic [31:0]      diag_a;
    logic [31:0]      diag_b;
    logic             clr_hit;

    pbh_regdec #(
        .NWORDS (NWORDS),
        .IDX_W  (IDX_W)
    ) u_dec (
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .wbit0     (reg_wdata[0]),
        .err_cfg   (err_cfg),
        .stat      (stat),
        .ien       (ien),
        .diag_a    (diag_a),
        .diag_b    (diag_b),
        .lut_rword (lut_rword),
        .cmd       (cmd),
        .lut_we    (lut_we),
        .lut_idx   (lut_idx),
        .reg_rdata (reg_rdata)
    );

    pbh_lut #(
        .ADDR_W    (ADDR_W),
        .BLK_SHIFT (BLK_SHIFT)
    ) u_lut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (lut_we),
        .wr_idx    (lut_idx),
        .wr_data   (reg_wdata),
        .rd_idx    (lut_idx),
        .rd_word   (lut_rword),
        .look_addr (blk_addr),
        .look_bit  (lut_bit)
    );

    pbh_capture #(
        .ADDR_W (ADDR_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_valid  (blk_valid),
        .blk_addr   (blk_addr),
        .blk_secure (blk_secure),
        .blk_req_id (blk_req_id),
        .lut_bit    (lut_bit),
        .cmd        (cmd),
        .err_cfg    (err_cfg),
        .stat       (stat),
        .ien        (ien),
        .diag_a     (diag_a),
        .diag_b     (diag_b),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err),
        .irq        (irq)
    );

    assign clr_hit   = cmd.wr_clr && cmd.bit0;
    assign rsp_rdata = '0;

endmodule

// File: rtl/pbh_checker.sv
`timescale 1ns/1ps
module pbh_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          blk_valid,
    input logic          rsp_valid,
    input logic          rsp_err,
    input logic [DW-1:0] rsp_rdata,
    input logic          err_cfg,
    input logic          stat,
    input logic          ien,
    input logic [31:0]   diag_a,
    input logic [31:0]   diag_b,
    input logic          clr_hit,
    input logic          irq
);

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |=> rsp_valid);

    p_no_stray_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_valid |=> !rsp_valid);

    p_rdata_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata == '0));

    p_err_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid |=> (rsp_err == $past(err_cfg)));

    p_capture_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !stat) |=> stat);

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat |=> ($stable(diag_a) && $stable(diag_b)));

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && stat) |=> !stat);

endmodule

bind prot_block_handler pbh_checker #(.DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_valid (blk_valid),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .err_cfg   (err_cfg),
    .stat      (stat),
    .ien       (ien),
    .diag_a    (diag_a),
    .diag_b    (diag_b),
    .clr_hit   (clr_hit),
    .irq       (irq)
);

// File: tb/sim_prot_block_handler.sv
`timescale 1ns/1ps
module sim_prot_block_handler;

    localparam int AW     = 16;
    localparam int BSH    = 8;
    localparam int NW     = 8;
    localparam int BLKSZ  = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_valid = 1'b0;
    logic [15:0] b_addr = '0;
    logic        b_sec = 1'b0;
    logic [15:0] b_rid = '0;
    logic        r_en = 1'b0;
    logic        r_we = 1'b0;
    logic [11:0] r_addr = '0;
    logic [31:0] r_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prot_block_handler #(.ADDR_W(AW), .BLK_SHIFT(BSH), .DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n),
        .blk_valid(b_valid), .blk_addr(b_addr), .blk_secure(b_sec), .blk_req_id(b_rid),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .reg_en(r_en), .reg_we(r_we), .reg_addr(r_addr), .reg_wdata(r_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit          m_err, m_stat, m_ien, m_rv, m_re;
    bit [31:0]   m_da, m_db;
    bit [31:0]   m_lut [NW];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_err = 0; m_stat = 0; m_ien = 0; m_rv = 0; m_re = 0;
            m_da = 0; m_db = 0;
            for (int i = 0; i < NW; i++) m_lut[i] = 0;
        end else begin
            bit capt;
            bit lbit;
            int bn;
            bit old_stat;
            old_stat = m_stat;
            bn   = int'(b_addr) / BLKSZ;
            lbit = m_lut[bn / 32][bn % 32];
            capt = b_valid && !old_stat;
            m_rv = b_valid;
            m_re = b_valid && m_err;
            if (capt) begin
                m_da = {16'd0, b_addr};
                m_db = {14'd0, lbit, ~b_sec, b_rid};
            end
            if (r_en && r_we) begin
                case (r_addr)
                    12'h000: m_err = r_wdata[0];
                    12'h028: m_ien = r_wdata[0];
                    12'h024: if (r_wdata[0]) m_stat = 0;
                    12'h034: if (r_wdata[0]) m_stat = 1;
                    default: begin
                        if (r_addr >= 12'h400 && r_addr < 12'h400 + 4*NW && r_addr[1:0] == 0)
                            m_lut[(int'(r_addr) - 'h400) / 4] = r_wdata;
                    end
                endcase
            end
            if (capt) m_stat = 1;
        end
    end

    function automatic bit [31:0] m_read(input bit [11:0] a);
        if (a >= 12'h400 && a < 12'h400 + 4*NW && a[1:0] == 0)
            return m_lut[(int'(a) - 'h400) / 4];
        case (a)
            12'h000: return {31'd0, m_err};
            12'h020: return {31'd0, m_stat};
            12'h028: return {31'd0, m_ien};
            12'h02C: return m_da;
            12'h030: return m_db;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input bit [11:0] a);
        if (a >= 12'h400) return "R6";
        case (a)
            12'h020: return "R9";
            12'h02C: return "R4";
            12'h030: return "R5";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: compare registered outputs, drive new stimulus, check any read
    task automatic step(input bit bv, input bit [15:0] ba, input bit bs, input bit [15:0] rid,
                        input bit ren, input bit rwe, input bit [11:0] ra, input bit [31:0] wd);
        @(negedge clk);
        chk("R2 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
        chk("R2 rsp_rdata", rsp_rdata, 32'd0);
        chk("R3 rsp_err", {31'd0, rsp_err}, {31'd0, m_re});
        chk("R8 irq", {31'd0, irq}, {31'd0, m_stat & m_ien});
        b_valid = bv; b_addr = ba; b_sec = bs; b_rid = rid;
        r_en = ren; r_we = rwe; r_addr = ra; r_wdata = wd;
        #1;
        if (ren && !rwe) chk(rd_tag(ra), reg_rdata, m_read(ra));
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wr(input bit [11:0] a, input bit [31:0] d);
        step(0, 0, 0, 0, 1, 1, a, d);
    endtask
    task automatic rd(input bit [11:0] a, input bit [31:0] exp, input string tag);
        step(0, 0, 0, 0, 1, 0, a, 0);
        chk(tag, reg_rdata, exp);
    endtask
    task automatic acc(input bit [15:0] a, input bit s, input bit [15:0] id);
        step(1, a, s, id, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rd(12'h000, 0, "R1 ctrl");
        rd(12'h020, 0, "R1 status");
        rd(12'h02C, 0, "R1 diagA");
        rd(12'h030, 0, "R1 diagB");
        for (int k = 0; k < NW; k++) rd(12'h400 + 12'(4*k), 0, "R1 table");

        // block 104 = word 3 bit 8 -> address 0x6800..0x68FF
        wr(12'h40C, 32'h0000_0100);
        wr(12'h028, 1);
        rd(12'h40C, 32'h0000_0100, "R6 table readback");
        acc(16'h6812, 0, 16'hBEEF);
        idle();
        chk("R3 okay response", {31'd0, rsp_err}, 32'd0);
        chk("R8 irq raised", {31'd0, irq}, 32'd1);
        rd(12'h02C, 32'h0000_6812, "R4 diagA");
        rd(12'h030, 32'h0003_BEEF, "R5 diagB");
        rd(12'h020, 1, "R4 status set");

        // R7: frozen while status set
        acc(16'h0004, 1, 16'h1234);
        idle();
        chk("R7 still answered", {31'd0, rsp_valid}, 32'd1);
        rd(12'h02C, 32'h0000_6812, "R7 diagA frozen");
        rd(12'h030, 32'h0003_BEEF, "R7 diagB frozen");

        // R3: error response
        wr(12'h000, 1);
        acc(16'h0010, 1, 16'h0001);
        idle();
        chk("R3 error response", {31'd0, rsp_err}, 32'd1);

        // R9: clear semantics
        wr(12'h024, 0);
        idle();
        rd(12'h020, 1, "R9 write 0 ignored");
        wr(12'h024, 1);
        idle();
        rd(12'h020, 0, "R9 cleared");
        chk("R8 irq low after clear", {31'd0, irq}, 32'd0);

        // R10: set forces status only
        wr(12'h034, 1);
        idle();
        rd(12'h020, 1, "R10 set");
        rd(12'h02C, 32'h0000_6812, "R10 diagA unchanged");
        chk("R8 irq from set", {31'd0, irq}, 32'd1);
        wr(12'h028, 0);
        idle();
        chk("R8 irq disabled", {31'd0, irq}, 32'd0);

        // R5/R6: secure access to a block whose table bit is 0
        wr(12'h024, 1);
        acc(16'h6712, 1, 16'h00A5);
        idle();
        rd(12'h030, 32'h0000_00A5, "R5 secure, table bit 0");

        // R6: table write in the same cycle as capture uses old word
        wr(12'h024, 1);
        step(1, 16'h0100, 0, 16'h0042, 1, 1, 12'h400, 32'hFFFF_FFFF);
        idle();
        rd(12'h030, 32'h0001_0042, "R6 old word used");
        rd(12'h400, 32'hFFFF_FFFF, "R6 write landed");
        wr(12'h024, 1);
        acc(16'h0100, 0, 16'h0042);
        idle();
        rd(12'h030, 32'h0003_0042, "R6 new word used");

        // R11: read-only and unmapped locations
        wr(12'h02C, 32'hDEAD_BEEF);
        wr(12'h030, 32'hDEAD_BEEF);
        rd(12'h02C, 32'h0000_0100, "R11 diagA write ignored");
        rd(12'h030, 32'h0003_0042, "R11 diagB write ignored");
        rd(12'h034, 0, "R11 set reads 0");
        rd(12'h420, 0, "R11 past last table word");

        // random mixed phase against the model
        for (int c = 0; c < 4000; c++) begin
            bit [11:0] ra;
            int sel;
            sel = $urandom % 12;
            case (sel)
                0: ra = 12'h000;  1: ra = 12'h020;  2: ra = 12'h024;
                3: ra = 12'h028;  4: ra = 12'h02C;  5: ra = 12'h030;
                6: ra = 12'h034;  7: ra = 12'h038;
                default: ra = 12'h400 + 12'(4 * ($urandom % 10));
            endcase
            step(($urandom % 3) == 0, 16'($urandom), 1'($urandom), 16'($urandom),
                 ($urandom % 2) == 0, ($urandom % 3) != 0, ra, $urandom);
        end
        idle();
        idle();

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule